// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block sits in the address path of a memory controller with two DIMM sockets. Each socket holds up to two rows, one per side, so there are four rows. For any physical address it works out which row holds the address. It reports that row as a one-hot select, together with the page-size code of that side. An address that lies above the installed memory, or that lands on a side marked as unpopulated, raises a miss flag, and no row is selected.

Configuration comes in through a single register-write port. Four boundary registers hold the running total of memory, in 32 MB units, up to and including each row. Rows 0 and 1 belong to socket 0, and rows 2 and 3 to socket 1. An absent DIMM or an absent second side adds nothing to the running total, so its row has zero width. Two spare boundary slots follow row 3. Configuration software writes them with row 3's value, and they have no effect on decoding. One attribute byte per socket holds a page-size nibble for each side.

Decoding is purely combinational from the stored registers. A register write is seen from the clock edge that stores it.

Top module: `dram_row_decoder`

## Requirements
- R1: After synchronous reset every boundary register is 0 and both attribute bytes are 0xFF, so every address gives miss=1, row_sel=0 and page_code=0.
- R2: On a rising edge with wr_en=1, wr_idx selects the target: 0 to 3 are the boundaries of rows 0 to 3, 4 and 5 are the spare slots, 6 is the socket 0 attribute byte and 7 is the socket 1 attribute byte. The new value affects the outputs from that edge on, and not before it.
- R3: Let unit be addr[31:25]. The selected row is the lowest index r whose boundary is strictly greater than unit, and row_sel bit r is set.
- R4: A row whose boundary equals the previous row's boundary (the previous boundary is 0 for row 0) is never selected. Addresses in that range fall through to the next row with a larger boundary.
- R5: When unit is greater than or equal to row 3's boundary, miss=1 and row_sel=0, whatever has been written to the spare slots 4 and 5.
- R6: Row 2s+k takes its page code from socket s's attribute byte: bits [3:0] when k=0 and bits [7:4] when k=1. Nibble values 0, 1, 2 and 3 (2, 4, 8 and 16 KB) appear unchanged on page_code.
- R7: When the selected row's nibble is greater than 3 (0xF marks an unpopulated side), miss=1, row_sel=0 and page_code=0.
- R8: row_sel has at most one bit set. miss is 1 exactly when row_sel is 0. page_code is 0 whenever miss is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register slot to write |
| wr_data | input | 8 | Write data |
| addr | input | 32 | Physical address to decode |
| row_sel | output | 4 | One-hot selected row |
| miss | output | 1 | Address not backed by a populated row |
| page_code | output | 2 | Page-size code of the selected row |

## Verification
An address change reaches row_sel, miss and page_code in the same cycle, with no register on the way. The bench therefore drives addresses on the falling edge and samples them 1 ns later. A register write passes through one register, so its effect appears just after the rising edge that follows the strobe. The R2 check samples once before that edge, where the old value must still be in force, and once just after it, where the new value must be in force. Every other check waits for a whole clock period after its last write before it samples.

// File: rtl/dram_row_pkg.sv
package dram_row_pkg;
    localparam int ROWS      = 4;
    localparam int SIDES     = 2;
    localparam int SOCKETS   = ROWS / SIDES;
    localparam int SPARE     = 2;
    localparam int SLOTS     = ROWS + SPARE + SOCKETS;
    localparam int IDX_W     = $clog2(SLOTS);
    localparam int ATTR_BASE = ROWS + SPARE;
    localparam int DATA_W    = 8;
    localparam int BND_W     = DATA_W;
    localparam int NIB_W     = 4;
    localparam int ATTR_W    = NIB_W * SIDES;
    localparam int ROW_W     = $clog2(ROWS);
    localparam int PAGE_W    = 2;

    typedef enum logic [PAGE_W-1:0] {
        PG_2K  = 2'd0,
        PG_4K  = 2'd1,
        PG_8K  = 2'd2,
        PG_16K = 2'd3
    } page_e;

    typedef struct packed {
        logic             hit;
        logic [ROW_W-1:0] idx;
        logic [ROWS-1:0]  first;
    } match_t;

    function automatic logic nib_is_page(input logic [NIB_W-1:0] nib);
        return nib < NIB_W'(4);
    endfunction

    function automatic page_e nib_to_page(input logic [NIB_W-1:0] nib);
        return page_e'(nib[PAGE_W-1:0]);
    endfunction
endpackage

// File: rtl/dram_row_regs.sv
module dram_row_regs
    import dram_row_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [ROWS-1:0][BND_W-1:0]     bnd_q,
    output logic [SOCKETS-1:0][ATTR_W-1:0] attr_q
);
    // Boundary registers, one per row. The spare slots carry no storage.
    for (genvar r = 0; r < ROWS; r++) begin : g_bnd
        always_ff @(posedge clk) begin
            if (rst) begin
                bnd_q[r] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(r)) begin
                bnd_q[r] <= wr_data[BND_W-1:0];
            end
        end
    end

    // Attribute bytes reset to "both sides unpopulated".
    for (genvar s = 0; s < SOCKETS; s++) begin : g_attr
        always_ff @(posedge clk) begin
            if (rst) begin
                attr_q[s] <= '1;
            end else if (wr_en && wr_idx == IDX_W'(ATTR_BASE + s)) begin
                attr_q[s] <= wr_data[ATTR_W-1:0];
            end
        end
    end
endmodule

// File: rtl/dram_row_match.sv
module dram_row_match
    import dram_row_pkg::*;
#(
    parameter int UNIT_W = 7
) (
    input  logic [UNIT_W-1:0]          unit,
    input  logic [ROWS-1:0][BND_W-1:0] bnd_q,
    output match_t                     match
);
    logic [BND_W-1:0] unit_ext;
    logic [ROWS-1:0]  above;

    assign unit_ext = BND_W'(unit);

    for (genvar r = 0; r < ROWS; r++) begin : g_cmp
        assign above[r] = bnd_q[r] > unit_ext;
    end

    // Lowest index whose cumulative boundary lies above the address.
    always_comb begin
        logic seen;
        seen        = 1'b0;
        match.first = '0;
        match.idx   = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (above[r] && !seen) begin
                match.first[r] = 1'b1;
                match.idx      = ROW_W'(r);
            end
            seen = seen | above[r];
        end
        match.hit = seen;
    end
endmodule

// File: rtl/dram_row_attr.sv
module dram_row_attr
    import dram_row_pkg::*;
(
    input  logic [SOCKETS-1:0][ATTR_W-1:0] attr_q,
    input  logic [ROW_W-1:0]               idx,
    output logic [NIB_W-1:0]               nib
);
    // Row r sits on socket r/SIDES, side r%SIDES.
    always_comb begin
        nib = '1;
        for (int r = 0; r < ROWS; r++) begin
            if (idx == ROW_W'(r)) begin
                nib = attr_q[r / SIDES][(r % SIDES) * NIB_W +: NIB_W];
            end
        end
    end
endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder
    import dram_row_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int UNIT_LSB = 25
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   addr,
    output logic [ROWS-1:0]     row_sel,
    output logic                miss,
    output logic [PAGE_W-1:0]   page_code
);
    localparam int UNIT_W = ADDR_W - UNIT_LSB;

    logic [ROWS-1:0][BND_W-1:0]     bnd_q;
    logic [SOCKETS-1:0][ATTR_W-1:0] attr_q;
    logic [UNIT_W-1:0]              unit;
    logic                           unused_low;
    match_t                         match;
    logic [NIB_W-1:0]               nib;
    logic                           valid;
    page_e                          page;

    assign unit       = addr[ADDR_W-1:UNIT_LSB];
    assign unused_low = ^addr[UNIT_LSB-1:0];

    dram_row_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .bnd_q   (bnd_q),
        .attr_q  (attr_q)
    );

    dram_row_match #(.UNIT_W(UNIT_W)) u_match (
        .unit  (unit),
        .bnd_q (bnd_q),
        .match (match)
    );

    dram_row_attr u_attr (
        .attr_q (attr_q),
        .idx    (match.idx),
        .nib    (nib)
    );

    assign valid     = match.hit && nib_is_page(nib);
    assign page      = valid ? nib_to_page(nib) : PG_2K;
    assign row_sel   = valid ? match.first : '0;
    assign miss      = !valid;
    assign page_code = page;
endmodule

// File: rtl/dram_row_decoder_chk.sv
module dram_row_decoder_chk
    import dram_row_pkg::*;
#(
    parameter int UNIT_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [UNIT_W-1:0] unit,
    input logic [BND_W-1:0]  top_bnd,
    input logic [ROWS-1:0]   row_sel,
    input logic              miss,
    input logic [PAGE_W-1:0] page_code
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_sel)); // R8
    AST_MISS_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        miss |-> row_sel == '0); // R8
    AST_HIT_HAS_SEL: assert property (@(posedge clk) disable iff (rst)
        !miss |-> row_sel != '0); // R8
    AST_MISS_PAGE_ZERO: assert property (@(posedge clk) disable iff (rst)
        miss |-> page_code == '0); // R7
    AST_RESET_MISS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> miss); // R1
    AST_ABOVE_TOP: assert property (@(posedge clk) disable iff (rst)
        (BND_W'(unit) >= top_bnd) |-> miss); // R5
    AST_TOP_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_W'(ROWS - 1)) |=> top_bnd == $past(wr_data)); // R2
endmodule

bind dram_row_decoder dram_row_decoder_chk #(.UNIT_W(ADDR_W - UNIT_LSB)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .unit      (unit),
    .top_bnd   (bnd_q[dram_row_pkg::ROWS-1]),
    .row_sel   (row_sel),
    .miss      (miss),
    .page_code (page_code)
);

// File: tb/dram_row_decoder_bench.sv
`timescale 1ns/1ps
module dram_row_decoder_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [7:0]  wr_data;
    logic [31:0] addr;
    logic [3:0]  row_sel;
    logic        miss;
    logic [1:0]  page_code;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    dram_row_decoder u_dram_row_decoder (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .addr(addr), .row_sel(row_sel), .miss(miss), .page_code(page_code)
    );

    task automatic check(input string tag, input logic [3:0] es, input logic em,
                         input logic [1:0] ep);
        total++;
        if (row_sel !== es || miss !== em || page_code !== ep) begin
            bad++;
            $display("FAIL %s: sel=%b miss=%b page=%0d expected sel=%b miss=%b page=%0d",
                     tag, row_sel, miss, page_code, es, em, ep);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a);
        @(negedge clk);
        addr = a;
        #1;
    endtask

    // unit = addr[31:25]
    function automatic logic [31:0] u2a(input int u);
        return 32'(u) << 25;
    endfunction

    task automatic t_reset;
        probe(32'h0);          check("R1 reset addr 0", 4'b0000, 1'b1, 2'd0);
        probe(32'hFFFF_FFFF);  check("R1 reset top addr", 4'b0000, 1'b1, 2'd0);
    endtask

    task automatic t_dual_single;
        // socket0 dual 128MB/side, socket1 single 64MB
        wr(0, 8'd4); wr(1, 8'd8); wr(2, 8'd10); wr(3, 8'd10);
        wr(4, 8'd10); wr(5, 8'd10);
        wr(6, 8'h22); wr(7, 8'hF1);
        probe(32'h0);           check("R3 row0 low", 4'b0001, 1'b0, 2'd2);
        probe(32'h07FF_FFFF);   check("R3 row0 last byte", 4'b0001, 1'b0, 2'd2);
        probe(u2a(4));          check("R6 row1 high nibble", 4'b0010, 1'b0, 2'd2);
        probe(u2a(9));          check("R4 row2 not zero-width row3", 4'b0100, 1'b0, 2'd1);
        probe(u2a(10));         check("R5 at top misses", 4'b0000, 1'b1, 2'd0);
    endtask

    task automatic t_write_timing;
        probe(u2a(5));          check("R2 before write row1", 4'b0010, 1'b0, 2'd2);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd0; wr_data = 8'd6;
        #1;                     check("R2 old value before edge", 4'b0010, 1'b0, 2'd2);
        @(posedge clk); #1;     check("R2 new value after edge", 4'b0001, 1'b0, 2'd2);
        @(negedge clk);
        wr_en = 1'b0;
        wr(0, 8'd4);
    endtask

    task automatic t_spare;
        wr(4, 8'h7F); wr(5, 8'h7F);
        probe(u2a(10));         check("R5 spare slots no effect", 4'b0000, 1'b1, 2'd0);
        probe(u2a(120));        check("R5 far above top", 4'b0000, 1'b1, 2'd0);
    endtask

    task automatic t_unpopulated;
        wr(7, 8'hFF);
        probe(u2a(9));          check("R7 side nibble F", 4'b0000, 1'b1, 2'd0);
        wr(6, 8'h52);
        probe(u2a(4));          check("R7 nibble 5 unsupported", 4'b0000, 1'b1, 2'd0);
        probe(u2a(1));          check("R6 low nibble 2", 4'b0001, 1'b0, 2'd2);
    endtask

    task automatic t_empty_socket0;
        wr(0, 8'd0); wr(1, 8'd0); wr(2, 8'd2); wr(3, 8'd4);
        wr(6, 8'hFF); wr(7, 8'h30);
        probe(32'h0);           check("R4 empty socket0 skipped", 4'b0100, 1'b0, 2'd0);
        probe(u2a(3));          check("R6 row3 16KB", 4'b1000, 1'b0, 2'd3);
        probe(u2a(4));          check("R5 above row3", 4'b0000, 1'b1, 2'd0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0; addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_dual_single;
        t_write_timing;
        t_spare;
        t_unpopulated;
        t_empty_socket0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule